// File: doc/BRIEF.md
# Beam Parameter Controller

This block keeps the three operator settings of a transmit channel: the steering phase, the drive amplitude and the waveform frequency. It also keeps two switches, one that runs the waveform and one that enables the output driver. Five push buttons step these settings. Each button passes through its own debouncer, and a press counts once however long the button is held.

When the phase or the amplitude changes, the block sends both values to the driver's register file over a four-wire serial link: data, clock, an active-low select and a load strobe. It sends them as two 16-bit frames. The frequency choice and the two switches go straight to the waveform sequencer. A press that arrives while frames are on the wire is remembered, and one more pair of frames follows the pair in progress, so the driver always ends up with the latest values. Three indicator outputs show a zero phase, a mid-scale amplitude and an enabled driver.

Top module: `beam_param_ctrl`

## Requirements
- R1: After reset the phase index is 0, the amplitude step is 7 (DAC code 127), freqSel is 0, runWave and drvEnable are 0, csN is 1, sck and ld are 0, ledPhaseZero and ledAmpMid are 1, and ledEnable is 0.
- R2: Each phase press adds one to the phase index, which counts 7.5-degree steps from 0 to 47; the step after 47 is 0. ledPhaseZero is 1 exactly when the index is 0.
- R3: Each amplitude press adds one to a 4-bit step, and the step after 15 is 0. The DAC code is step*16+15, so step 15 gives 255. ledAmpMid is 1 exactly when the code is 127.
- R4: Each frequency press moves freqSel through 0, 1, 2 and back to 0, selecting 12, 16 or 20 samples per cycle.
- R5: A waveform press toggles runWave and an enable press toggles drvEnable. ledEnable follows drvEnable. Neither press starts a serial transfer.
- R6: A button level that lasts fewer than DEBOUNCE_CYCLES clocks has no effect. A button held for any longer time acts exactly once.
- R7: After a phase or amplitude press, two frames follow, each sent MSB first. The first is address 0x10 with the phase index in the low bits of the data byte. The second is address 0x20 with the DAC code. Each frame carries the values that hold when that frame starts.
- R8: csN stays low for the whole frame, and each frame has exactly 16 rising sck edges. sck is low whenever csN is high. While csN is low, sdi changes only in the cycle in which sck falls.
- R9: ld is high for exactly one clock, in the cycle after csN rises, and csN is high during it.
- R10: If a phase or amplitude press arrives while a frame pair is in progress, one more pair is sent after it, carrying the updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| btnPhase | input | 1 | Phase step button, high when pressed |
| btnAmpl | input | 1 | Amplitude step button, high when pressed |
| btnFreq | input | 1 | Frequency select button, high when pressed |
| btnWav | input | 1 | Waveform run toggle button, high when pressed |
| btnEna | input | 1 | Driver enable toggle button, high when pressed |
| sdi | output | 1 | Serial data to the driver |
| sck | output | 1 | Serial clock, idle low; the driver samples sdi on the rising edge |
| csN | output | 1 | Active-low frame select |
| ld | output | 1 | Register load strobe |
| freqSel | output | 2 | Samples-per-cycle choice for the sequencer |
| runWave | output | 1 | Waveform run flag for the sequencer |
| drvEnable | output | 1 | Active-high driver enable |
| ledPhaseZero | output | 1 | Lit when the phase index is zero |
| ledAmpMid | output | 1 | Lit when the DAC code is mid-scale |
| ledEnable | output | 1 | Lit when the driver is enabled |

## Verification
Properties are checked on every cycle for the serial framing: sck is idle while the select is high, sdi changes only on falling sck edges, and the load pulse has its place and width. They also check that the phase index never leaves its range, that the phase and amplitude wrap at their tops, that a debounced press lasts one cycle and that the frequency code is never 3. Only the bench scenarios can show the frame contents, the pairing and ordering of frames, that toggle presses send no frame, that a short glitch is rejected, and that a press made during a transfer leads to a second pair with the new values.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int BTN_COUNT = 5;
  localparam int IDX_PHASE = 0;
  localparam int IDX_AMPL  = 1;
  localparam int IDX_FREQ  = 2;
  localparam int IDX_WAV   = 3;
  localparam int IDX_ENA   = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HI, S_LO, S_CSH, S_LD
  } ser_state_t;

  // strobes from the serial sequencer to the datapath
  typedef struct packed {
    logic loadFrame;  // load a new word into the shifter
    logic loadDac;    // 1: DAC frame, 0: phase frame
    logic shiftOut;   // advance to the next bit
  } ser_strobe_t;
endpackage

// File: rtl/bpc_debounce.sv
module bpc_debounce #(
  parameter int DEB_CYCLES = 1600000
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic pressOut
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic syncA, syncB, stable;
  logic [CNT_W-1:0] cnt;
  logic settled;

  assign settled = (cnt == CNT_W'(DEB_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      stable   <= 1'b0;
      cnt      <= '0;
      pressOut <= 1'b0;
    end else begin
      syncA    <= rawIn;
      syncB    <= syncA;
      pressOut <= 1'b0;
      if (syncB == stable) begin
        cnt <= '0;
      end else if (settled) begin
        cnt      <= '0;
        stable   <= syncB;
        pressOut <= syncB;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: a press lasts one cycle
  p_press_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    pressOut |=> !pressOut);
endmodule

// File: rtl/bpc_datapath.sv
module bpc_datapath
  import bpc_pkg::*;
#(
  parameter int PHASE_STEPS  = 48,
  parameter int AMP_BITS     = 4,
  parameter int AMP_RESET    = 7,
  parameter int DAC_BITS     = 8,
  parameter int ADDR_BITS    = 8,
  parameter logic [ADDR_BITS-1:0] PHASE_ADDR = 'h10,
  parameter logic [ADDR_BITS-1:0] DAC_ADDR   = 'h20,
  parameter int FREQ_CHOICES = 3,
  parameter int FREQ_SEL_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BTN_COUNT-1:0]  pressVec,
  input  ser_strobe_t           strobe,
  output logic                  sdi,
  output logic [FREQ_SEL_W-1:0] freqSel,
  output logic                  runWave,
  output logic                  drvEnable,
  output logic                  ledPhaseZero,
  output logic                  ledAmpMid,
  output logic                  ledEnable
);
  localparam int PHASE_W   = $clog2(PHASE_STEPS);
  localparam int LOW_BITS  = DAC_BITS - AMP_BITS;
  localparam int WORD_BITS = ADDR_BITS + DAC_BITS;
  localparam logic [DAC_BITS-1:0] MID_CODE = DAC_BITS'((1 << (DAC_BITS - 1)) - 1);
  localparam logic [PHASE_W-1:0] PHASE_TOP = PHASE_W'(PHASE_STEPS - 1);
  localparam logic [FREQ_SEL_W-1:0] FREQ_TOP = FREQ_SEL_W'(FREQ_CHOICES - 1);

  logic [PHASE_W-1:0]   phaseIdx;
  logic [AMP_BITS-1:0]  ampStep;
  logic [DAC_BITS-1:0]  dacCode;
  logic [WORD_BITS-1:0] shReg;
  logic [WORD_BITS-1:0] nextWord;

  assign dacCode = {ampStep, {LOW_BITS{1'b1}}};

  always_comb begin
    if (strobe.loadDac)
      nextWord = {DAC_ADDR, dacCode};
    else
      nextWord = {PHASE_ADDR, {(DAC_BITS - PHASE_W){1'b0}}, phaseIdx};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseIdx  <= '0;
      ampStep   <= AMP_BITS'(AMP_RESET);
      freqSel   <= '0;
      runWave   <= 1'b0;
      drvEnable <= 1'b0;
    end else begin
      if (pressVec[IDX_PHASE])
        phaseIdx <= (phaseIdx == PHASE_TOP) ? '0 : phaseIdx + 1'b1;
      if (pressVec[IDX_AMPL])
        ampStep <= ampStep + 1'b1;
      if (pressVec[IDX_FREQ])
        freqSel <= (freqSel == FREQ_TOP) ? '0 : freqSel + 1'b1;
      if (pressVec[IDX_WAV])
        runWave <= ~runWave;
      if (pressVec[IDX_ENA])
        drvEnable <= ~drvEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shReg <= '0;
    else if (strobe.loadFrame)
      shReg <= nextWord;
    else if (strobe.shiftOut)
      shReg <= {shReg[WORD_BITS-2:0], 1'b0};
  end

  assign sdi          = shReg[WORD_BITS-1];
  assign ledPhaseZero = (phaseIdx == '0);
  assign ledAmpMid    = (dacCode == MID_CODE);
  assign ledEnable    = drvEnable;

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    phaseIdx <= PHASE_TOP);
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pressVec[IDX_PHASE] && phaseIdx == PHASE_TOP) |=> (phaseIdx == '0));
  p_amp_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pressVec[IDX_AMPL] && ampStep == '1) |=> (ampStep == '0));
  p_freq_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    freqSel <= FREQ_TOP);
endmodule

// File: rtl/bpc_ctrl.sv
module bpc_ctrl
  import bpc_pkg::*;
#(
  parameter int SCK_HALF  = 2,
  parameter int WORD_BITS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output ser_strobe_t strobe,
  output logic        sck,
  output logic        csN,
  output logic        ld
);
  localparam int HALF_W = $clog2(SCK_HALF + 1);
  localparam int BIT_W  = $clog2(WORD_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  ser_state_t        state;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              frameDac;
  logic              pending;
  logic              reqQ;
  logic              halfDone;
  logic              restart;

  assign halfDone = (halfCnt == HALF_W'(SCK_HALF - 1));
  assign restart  = (state == S_LD) && frameDac && (pending || reqQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      halfCnt  <= '0;
      bitCnt   <= '0;
      frameDac <= 1'b0;
      pending  <= 1'b0;
      reqQ     <= 1'b0;
    end else begin
      reqQ <= startReq;
      if (restart || (state == S_IDLE && reqQ))
        pending <= 1'b0;
      else if (reqQ && state != S_IDLE)
        pending <= 1'b1;

      unique case (state)
        S_IDLE: if (reqQ) begin
          state    <= S_SETUP;
          frameDac <= 1'b0;
          halfCnt  <= '0;
          bitCnt   <= '0;
        end
        S_SETUP: if (halfDone) begin
          state   <= S_HI;
          halfCnt <= '0;
        end else halfCnt <= halfCnt + 1'b1;
        S_HI: if (halfDone) begin
          halfCnt <= '0;
          state   <= (bitCnt == LAST_BIT) ? S_CSH : S_LO;
        end else halfCnt <= halfCnt + 1'b1;
        S_LO: if (halfDone) begin
          halfCnt <= '0;
          bitCnt  <= bitCnt + 1'b1;
          state   <= S_HI;
        end else halfCnt <= halfCnt + 1'b1;
        S_CSH: state <= S_LD;
        S_LD: begin
          halfCnt <= '0;
          bitCnt  <= '0;
          if (!frameDac) begin
            frameDac <= 1'b1;
            state    <= S_SETUP;
          end else if (restart) begin
            frameDac <= 1'b0;
            state    <= S_SETUP;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadFrame = ((state == S_IDLE) && reqQ) ||
                       ((state == S_LD) && (!frameDac || restart));
    strobe.loadDac   = (state == S_LD) && !frameDac;
    strobe.shiftOut  = (state == S_HI) && halfDone && (bitCnt != LAST_BIT);
  end

  assign sck = (state == S_HI);
  assign csN = !((state == S_SETUP) || (state == S_HI) || (state == S_LO));
  assign ld  = (state == S_LD);

  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  p_ld_after_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    ld |-> (csN && $past(csN)));
  p_ld_follows_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> ld);
  p_ld_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ld |=> !ld);
endmodule

// File: rtl/beam_param_ctrl.sv
module beam_param_ctrl
  import bpc_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1600000,
  parameter int SCK_HALF        = 2,
  parameter int PHASE_STEPS     = 48,
  parameter int AMP_BITS        = 4,
  parameter int AMP_RESET       = 7,
  parameter int DAC_BITS        = 8,
  parameter int ADDR_BITS       = 8,
  parameter logic [ADDR_BITS-1:0] PHASE_ADDR = 'h10,
  parameter logic [ADDR_BITS-1:0] DAC_ADDR   = 'h20,
  parameter int FREQ_CHOICES    = 3,
  parameter int FREQ_SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  btnPhase,
  input  logic                  btnAmpl,
  input  logic                  btnFreq,
  input  logic                  btnWav,
  input  logic                  btnEna,
  output logic                  sdi,
  output logic                  sck,
  output logic                  csN,
  output logic                  ld,
  output logic [FREQ_SEL_W-1:0] freqSel,
  output logic                  runWave,
  output logic                  drvEnable,
  output logic                  ledPhaseZero,
  output logic                  ledAmpMid,
  output logic                  ledEnable
);
  localparam int WORD_BITS = ADDR_BITS + DAC_BITS;

  logic [BTN_COUNT-1:0] btnRaw;
  logic [BTN_COUNT-1:0] pressVec;
  ser_strobe_t          strobe;

  assign btnRaw[IDX_PHASE] = btnPhase;
  assign btnRaw[IDX_AMPL]  = btnAmpl;
  assign btnRaw[IDX_FREQ]  = btnFreq;
  assign btnRaw[IDX_WAV]   = btnWav;
  assign btnRaw[IDX_ENA]   = btnEna;

  for (genvar b = 0; b < BTN_COUNT; b++) begin : g_deb
    bpc_debounce #(.DEB_CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk(clk), .rstN(rstN), .rawIn(btnRaw[b]), .pressOut(pressVec[b])
    );
  end

  bpc_ctrl #(.SCK_HALF(SCK_HALF), .WORD_BITS(WORD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(pressVec[IDX_PHASE] | pressVec[IDX_AMPL]),
    .strobe(strobe), .sck(sck), .csN(csN), .ld(ld)
  );

  bpc_datapath #(
    .PHASE_STEPS(PHASE_STEPS), .AMP_BITS(AMP_BITS), .AMP_RESET(AMP_RESET),
    .DAC_BITS(DAC_BITS), .ADDR_BITS(ADDR_BITS), .PHASE_ADDR(PHASE_ADDR),
    .DAC_ADDR(DAC_ADDR), .FREQ_CHOICES(FREQ_CHOICES), .FREQ_SEL_W(FREQ_SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pressVec(pressVec), .strobe(strobe),
    .sdi(sdi), .freqSel(freqSel), .runWave(runWave), .drvEnable(drvEnable),
    .ledPhaseZero(ledPhaseZero), .ledAmpMid(ledAmpMid), .ledEnable(ledEnable)
  );

  // R8: data moves only together with a falling serial clock inside a frame
  p_sdi_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && !$fell(sck)) |-> $stable(sdi));
endmodule

// File: tb/sim_beam_param_ctrl.sv
module sim_beam_param_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 8;
  localparam int HALF = 2;
  localparam int SETTLE = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] btns = '0;
  logic sdi, sck, csN, ld, runWave, drvEnable, ledPhaseZero, ledAmpMid, ledEnable;
  logic [1:0] freqSel;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  beam_param_ctrl #(.DEBOUNCE_CYCLES(DEB), .SCK_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN),
    .btnPhase(btns[0]), .btnAmpl(btns[1]), .btnFreq(btns[2]),
    .btnWav(btns[3]), .btnEna(btns[4]),
    .sdi(sdi), .sck(sck), .csN(csN), .ld(ld), .freqSel(freqSel),
    .runWave(runWave), .drvEnable(drvEnable), .ledPhaseZero(ledPhaseZero),
    .ledAmpMid(ledAmpMid), .ledEnable(ledEnable)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // frame capture
  logic [15:0] capWords [0:63];
  logic [15:0] shWord = '0;
  int bitCount = 0;
  int capCount = 0;
  int badFrames = 0;
  int badLd = 0;

  always @(posedge sck or posedge ld) begin
    if (ld) begin
      capWords[capCount % 64] = shWord;
      if (bitCount != 16) badFrames = badFrames + 1;
      if (!csN) badLd = badLd + 1;
      capCount = capCount + 1;
      bitCount = 0;
    end else if (!csN) begin
      shWord = {shWord[14:0], sdi};
      bitCount = bitCount + 1;
    end
  end

  // btn, phase, code, freqSel, run, enable
  localparam logic [20:0] VECS [0:11] = '{
    {3'd0, 6'd1, 8'd127, 2'd0, 1'b0, 1'b0},
    {3'd1, 6'd1, 8'd143, 2'd0, 1'b0, 1'b0},
    {3'd1, 6'd1, 8'd159, 2'd0, 1'b0, 1'b0},
    {3'd2, 6'd1, 8'd159, 2'd1, 1'b0, 1'b0},
    {3'd2, 6'd1, 8'd159, 2'd2, 1'b0, 1'b0},
    {3'd2, 6'd1, 8'd159, 2'd0, 1'b0, 1'b0},
    {3'd3, 6'd1, 8'd159, 2'd0, 1'b1, 1'b0},
    {3'd4, 6'd1, 8'd159, 2'd0, 1'b1, 1'b1},
    {3'd0, 6'd2, 8'd159, 2'd0, 1'b1, 1'b1},
    {3'd3, 6'd2, 8'd159, 2'd0, 1'b0, 1'b1},
    {3'd4, 6'd2, 8'd159, 2'd0, 1'b0, 1'b0},
    {3'd1, 6'd2, 8'd175, 2'd0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pressBtn(input int b, input int hold);
    @(negedge clk);
    btns[b] = 1'b1;
    repeat (hold) @(negedge clk);
    btns[b] = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic checkPair(input int base, input int ph, input int code);
    check("R7 frame count", capCount - base, 2);
    check("R7 phase frame", int'(capWords[base % 64]), 'h1000 + ph);
    check("R7 dac frame", int'(capWords[(base + 1) % 64]), 'h2000 + code);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csN", csN, 1);
    check("R1 sck", sck, 0);
    check("R1 ld", ld, 0);
    check("R1 freqSel", freqSel, 0);
    check("R1 runWave", runWave, 0);
    check("R1 drvEnable", drvEnable, 0);
    check("R1 ledPhaseZero", ledPhaseZero, 1);
    check("R1 ledAmpMid", ledAmpMid, 1);
    check("R1 ledEnable", ledEnable, 0);

    for (int i = 0; i < 12; i++) begin
      logic [20:0] v;
      v = VECS[i];
      base = capCount;
      pressBtn(int'(v[20:18]), DEB + 4);
      check("R4 freqSel", freqSel, int'(v[3:2]));
      check("R5 runWave", runWave, int'(v[1]));
      check("R5 drvEnable", drvEnable, int'(v[0]));
      check("R5 ledEnable", ledEnable, int'(v[0]));
      check("R2 ledPhaseZero", ledPhaseZero, int'(v[17:12] == 6'd0));
      check("R3 ledAmpMid", ledAmpMid, int'(v[11:4] == 8'd127));
      if (v[20:18] < 3'd2) checkPair(base, int'(v[17:12]), int'(v[11:4]));
      else check("R5 no frame", capCount - base, 0);
    end

    // R2 phase wrap: index 2 up to 47, then to 0
    for (int k = 3; k <= 47; k++) pressBtn(0, DEB + 4);
    check("R2 led at 47", ledPhaseZero, 0);
    base = capCount;
    pressBtn(0, DEB + 4);
    checkPair(base, 0, 175);
    check("R2 led after wrap", ledPhaseZero, 1);

    // R3 amplitude wrap: step 10 up to 15, then to 0
    for (int k = 11; k <= 14; k++) pressBtn(1, DEB + 4);
    base = capCount;
    pressBtn(1, DEB + 4);
    check("R3 top code", int'(capWords[(base + 1) % 64]), 'h20FF);
    base = capCount;
    pressBtn(1, DEB + 4);
    check("R3 wrapped code", int'(capWords[(base + 1) % 64]), 'h200F);
    check("R3 ledAmpMid", ledAmpMid, 0);

    // R6 glitch shorter than the debounce time
    base = capCount;
    pressBtn(0, DEB - 5);
    check("R6 glitch frames", capCount - base, 0);
    check("R6 glitch phase", ledPhaseZero, 1);
    // R6 long hold acts once
    base = capCount;
    pressBtn(1, 300);
    checkPair(base, 0, 31);

    // R10 press during transfer
    base = capCount;
    @(negedge clk);
    btns[0] = 1'b1;
    while (csN) @(negedge clk);
    btns[1] = 1'b1;
    repeat (DEB + 4) @(negedge clk);
    btns = '0;
    repeat (600) @(negedge clk);
    check("R10 frame count", capCount - base, 4);
    check("R10 phase frame", int'(capWords[(base + 2) % 64]), 'h1001);
    check("R10 dac frame", int'(capWords[(base + 3) % 64]), 'h202F);

    check("R8 bits per frame", badFrames, 0);
    check("R9 ld with csN high", badLd, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end
endmodule